// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block picks the single local interrupt a hart should take right now. It receives the pending and enable vectors, a per-interrupt delegation mask, the hart's current privilege level, and the two global interrupt-enable bits, one for machine level and one for supervisor level. Each candidate interrupt is qualified by the global enable of the level it is routed to: machine level when its delegation bit is clear, supervisor level when it is set. Whether that level is open depends on the current privilege.

Among the qualified interrupts the lowest-numbered one wins. The result is a valid flag and a cause word ready for trap entry. The word carries an interrupt marker in its top bit and the winning index in its low bits. By default the outputs are registered, so they follow the inputs by one clock. A parameter selects a purely combinational variant.

Top module: `irq_sel`

## Requirements
- R1: An interrupt can win only when both its pending bit and its enable bit are 1. If either is 0, that interrupt never appears on the outputs.
- R2: Privilege is encoded 2'b00 = user, 2'b01 = supervisor, 2'b11 = machine; 2'b10 counts as below machine and above supervisor. The machine-level gate is open whenever privilege is not machine. In machine mode it is open only if `m_glob_ie` is 1.
- R3: The supervisor-level gate is open in user mode. In supervisor mode it is open only if `s_glob_ie` is 1. In machine mode and for code 2'b10 it is closed, whatever `s_glob_ie` is.
- R4: A candidate with its `irq_deleg` bit at 0 qualifies only through the machine-level gate. A candidate with its `irq_deleg` bit at 1 qualifies only through the supervisor-level gate.
- R5: When several interrupts qualify, the one with the lowest bit index is selected.
- R6: When no interrupt qualifies, `take_vld` is 0 and `take_cause` is all zeros.
- R7: When `take_vld` is 1, `take_cause` has bit 31 set, the winning index in bits [3:0], and every other bit at 0.
- R8: With the default registered output, the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` forces `take_vld` to 0 and `take_cause` to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 16 | Pending interrupt bits |
| irq_en | input | 16 | Per-interrupt enable bits |
| irq_deleg | input | 16 | Delegation mask; 1 routes the interrupt to supervisor level |
| priv_lvl | input | 2 | Current privilege level |
| m_glob_ie | input | 1 | Machine-level global interrupt enable |
| s_glob_ie | input | 1 | Supervisor-level global interrupt enable |
| take_vld | output | 1 | An interrupt should be taken |
| take_cause | output | 32 | Cause word: interrupt marker in bit 31, index in low bits |

## Verification
The assertions are checked on every cycle. They cover the following: the qualified set stays inside pending-and-enabled, machine mode never lets a delegated interrupt through, a non-delegated interrupt is never let through in machine mode while `m_glob_ie` is low, the selected index is set and has no lower qualified bit, the outputs lag the selector by exactly one edge, and the cause-word format. Other behaviours can only be shown by the bench's scenarios. These are the exact gate decisions for every privilege and enable combination, the odd privilege code, and reset arriving while interrupts are pending. The bench covers them by comparing every output against a model across directed cases and a long random sweep.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam logic [1:0] PRIV_USER  = 2'b00;
  localparam logic [1:0] PRIV_SUPER = 2'b01;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

  typedef struct packed {
    logic m_open;
    logic s_open;
  } gate_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] deleg,
  input  logic [1:0]         priv,
  input  logic               m_ie,
  input  logic               s_ie,
  output logic [NUM_IRQ-1:0] elig
);
  gate_t gate;

  always_comb begin
    gate.m_open = (priv != PRIV_MACH) || m_ie;
    gate.s_open = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_ie);
  end

  logic [NUM_IRQ-1:0] cand;
  assign cand = pend & en;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    assign elig[g] = cand[g] & (deleg[g] ? gate.s_open : gate.m_open);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               vld,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    vld = |req;
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_sel.sv
module irq_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int CAUSE_W = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic [1:0]         priv_lvl,
  input  logic               m_glob_ie,
  input  logic               s_glob_ie,
  output logic               take_vld,
  output logic [CAUSE_W-1:0] take_cause
);
  logic [NUM_IRQ-1:0] elig;
  logic               win_vld;
  logic [IDX_W-1:0]   win_idx;
  logic [CAUSE_W-1:0] cause_nxt;

  irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend (irq_pend),
    .en   (irq_en),
    .deleg(irq_deleg),
    .priv (priv_lvl),
    .m_ie (m_glob_ie),
    .s_ie (s_glob_ie),
    .elig (elig)
  );

  irq_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .req(elig),
    .vld(win_vld),
    .idx(win_idx)
  );

  always_comb begin
    cause_nxt = '0;
    if (win_vld) begin
      cause_nxt[CAUSE_W-1] = 1'b1;
      cause_nxt[IDX_W-1:0] = win_idx;
    end
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        take_vld   <= 1'b0;
        take_cause <= '0;
      end else begin
        take_vld   <= win_vld;
        take_cause <= cause_nxt;
      end
    end

    // R8
    out_lag_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (take_vld == $past(win_vld)) && (take_cause == $past(cause_nxt)));
  end else begin : g_comb
    assign take_vld   = win_vld;
    assign take_cause = cause_nxt;
  end

  // R1
  cand_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (elig & ~(irq_pend & irq_en)) == '0);

  // R3
  mach_no_deleg_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == PRIV_MACH) |-> ((elig & irq_deleg) == '0));

  // R2
  mach_ie_off_chk: assert property (@(posedge clk) disable iff (rst)
    ((priv_lvl == PRIV_MACH) && !m_glob_ie) |-> (elig == '0));

  // R5
  lowest_win_chk: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (elig[win_idx] &&
                 ((elig & ((NUM_IRQ'(1) << win_idx) - NUM_IRQ'(1))) == '0)));

  // R6
  none_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !take_vld |-> (take_cause == '0));

  // R7
  cause_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> (take_cause[CAUSE_W-1] &&
                  (take_cause[CAUSE_W-2:IDX_W] == '0)));
endmodule

// File: tb/sim_irq_sel.sv
module sim_irq_sel;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_pend, irq_en, irq_deleg;
  logic [1:0]  priv_lvl;
  logic        m_glob_ie, s_glob_ie;
  logic        take_vld;
  logic [31:0] take_cause;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  irq_sel u0 (
    .clk(clk), .rst(rst),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_deleg(irq_deleg),
    .priv_lvl(priv_lvl), .m_glob_ie(m_glob_ie), .s_glob_ie(s_glob_ie),
    .take_vld(take_vld), .take_cause(take_cause)
  );

  function automatic logic [32:0] model(logic [15:0] p, logic [15:0] e,
                                        logic [15:0] d, logic [1:0] pv,
                                        logic mie, logic sie);
    logic m_ok, s_ok;
    m_ok = (pv != 2'b11) || mie;
    s_ok = (pv == 2'b00) || ((pv == 2'b01) && sie);
    for (int i = 0; i < 16; i++) begin
      if (p[i] && e[i] && (d[i] ? s_ok : m_ok))
        return {1'b1, 1'b1, 27'd0, 4'(i)};
    end
    return 33'd0;
  endfunction

  task automatic compare(logic [32:0] exp, string tag);
    n_vec++;
    if ({take_vld, take_cause} !== exp) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b cause=%h, expected vld=%0b cause=%h",
               tag, take_vld, take_cause, exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(logic [15:0] p, logic [15:0] e, logic [15:0] d,
                       logic [1:0] pv, logic mie, logic sie, string tag);
    @(negedge clk);
    irq_pend = p; irq_en = e; irq_deleg = d;
    priv_lvl = pv; m_glob_ie = mie; s_glob_ie = sie;
    @(posedge clk);
    #5;
    compare(model(p, e, d, pv, mie, sie), tag);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      n_vec++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    irq_pend = 16'hFFFF; irq_en = 16'hFFFF; irq_deleg = 16'h0;
    priv_lvl = 2'b00; m_glob_ie = 1'b1; s_glob_ie = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    compare(33'd0, "R8 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R1: pending without enable, enable without pending
    apply(16'h00F0, 16'h000F, 16'h0, 2'b00, 1'b1, 1'b1, "R1 disjoint");
    apply(16'h0030, 16'h0020, 16'h0, 2'b00, 1'b0, 1'b0, "R1 overlap");
    // R2: machine gate
    apply(16'h0100, 16'hFFFF, 16'h0, 2'b11, 1'b0, 1'b1, "R2 M mie off");
    apply(16'h0100, 16'hFFFF, 16'h0, 2'b11, 1'b1, 1'b0, "R2 M mie on");
    apply(16'h0100, 16'hFFFF, 16'h0, 2'b01, 1'b0, 1'b0, "R2 S below M");
    apply(16'h0100, 16'hFFFF, 16'h0, 2'b10, 1'b0, 1'b0, "R2 code2 below M");
    // R3: supervisor gate
    apply(16'h0200, 16'hFFFF, 16'hFFFF, 2'b11, 1'b1, 1'b1, "R3 M closes S");
    apply(16'h0200, 16'hFFFF, 16'hFFFF, 2'b01, 1'b1, 1'b0, "R3 S sie off");
    apply(16'h0200, 16'hFFFF, 16'hFFFF, 2'b01, 1'b0, 1'b1, "R3 S sie on");
    apply(16'h0200, 16'hFFFF, 16'hFFFF, 2'b00, 1'b0, 1'b0, "R3 U open");
    apply(16'h0200, 16'hFFFF, 16'hFFFF, 2'b10, 1'b1, 1'b1, "R3 code2 closed");
    // R4: mixed delegation, lower delegated bit blocked, higher machine bit wins
    apply(16'h0012, 16'hFFFF, 16'h0002, 2'b11, 1'b1, 1'b1, "R4 mixed M");
    apply(16'h0012, 16'hFFFF, 16'h0010, 2'b01, 1'b1, 1'b0, "R4 mixed S");
    // R5: lowest index
    apply(16'hFFFF, 16'hFFFF, 16'h0, 2'b00, 1'b0, 1'b0, "R5 all set");
    apply(16'h8000, 16'hFFFF, 16'h0, 2'b00, 1'b0, 1'b0, "R5 top bit");
    apply(16'hA400, 16'hFFFF, 16'h0, 2'b11, 1'b1, 1'b0, "R5 three set");
    // R6/R7
    apply(16'h0000, 16'hFFFF, 16'h0, 2'b00, 1'b1, 1'b1, "R6 none");
    apply(16'h0001, 16'h0001, 16'h0, 2'b00, 1'b1, 1'b1, "R7 index zero");

    // R8: synchronous reset with pending interrupts
    @(negedge clk);
    irq_pend = 16'h0004; irq_en = 16'hFFFF; irq_deleg = 16'h0;
    priv_lvl = 2'b00; rst = 1'b1;
    @(posedge clk);
    #5;
    compare(33'd0, "R8 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    compare(model(16'h0004, 16'hFFFF, 16'h0, 2'b00, m_glob_ie, s_glob_ie),
            "R8 after reset");

    // Random sweep across R1..R7
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] pv;
      logic [15:0] p, e;
      pv = 2'($urandom_range(0, 3));
      p = 16'($urandom) & 16'($urandom);
      e = 16'($urandom) | 16'($urandom);
      apply(p, e, 16'($urandom), pv, 1'($urandom), 1'($urandom),
            "R5 random sweep");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule